// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides its input clock by an integer chosen at run time. An internal counter walks from zero up to the divisor minus one and then wraps. The output is high while the counter is below a separately programmed high-phase length, and low for the rest of each period. A programmable starting count picks where in the period the counter begins, which sets the phase of the output.

Three configuration inputs give the divisor, the high-phase length and the starting count. They are captured into internal registers only when a load strobe is asserted. A synchronous reset puts in built-in defaults: divisor 2, high phase 1 and starting count 0. Either event restarts the counter from the starting count on that edge. The divided clock comes straight from a flip-flop that updates only on rising input edges, so it cannot glitch.

Top module: `clk_div_top`

## Requirements
- R1: On the edge where `rst` is high, the block takes the defaults (divisor 2, high phase 1, start 0). From the next cycle on, `divClkOut` reads 1, 0, 1, 0, and so on.
- R2: After a load with divisor N ≥ 2, `divClkOut` repeats with a period of exactly N input cycles.
- R3: Within each period, `divClkOut` is high for exactly H consecutive cycles, where H is the high-phase length and 0 < H < N. The period starts at count 0.
- R4: After a load, the first output cycle corresponds to count S, where S is the starting count. The output is 1 when S < H. From then on the count advances by one each cycle and wraps to 0 after N-1.
- R5: A starting count S ≥ N is reduced to S mod N when loaded.
- R6: A divisor of 0 or 1 means divide-by-1, and `divClkOut` then stays 1 whatever the high-phase length is.
- R7: A high-phase length of 0 holds `divClkOut` at 0. A high-phase length ≥ N holds it at 1.
- R8: Changes on `divisorIn`, `highCyclesIn` and `initCountIn` while `loadStrobe` is low have no effect on `divClkOut`.
- R9: A load in the middle of a period takes effect on that edge. The counter restarts from the new starting count, and no part of the old period is finished first.
- R10: When `rst` and `loadStrobe` are high in the same cycle, reset wins and the defaults are loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; loads the defaults |
| loadStrobe | input | 1 | Captures the three configuration inputs and restarts the counter |
| divisorIn | input | CNT_W | Divisor N |
| highCyclesIn | input | CNT_W | High-phase length H in input cycles |
| initCountIn | input | CNT_W | Starting count S |
| divClkOut | output | 1 | Divided clock, registered |

## Verification
Reset and a load strobe can both be asserted on the same edge, and each of them would capture a different configuration. The bench raises both together while presenting a configuration that would hold the output low: divisor 5 and high phase 0. It then checks that the output follows the default 1, 0, 1, 0 pattern. A second collision occurs when a reload lands in the middle of a period while the counter is advancing. The bench judges that case by checking that the output immediately takes the phase of the new starting count.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;      // load config registers and restart counter
    logic takeDefaults; // use built-in defaults instead of inputs
  } divStrobe_t;

endpackage

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
  import clk_div_pkg::*;
(
  input  logic       rst,
  input  logic       loadStrobe,
  output divStrobe_t strb
);

  // Reset has priority over a user load in the same cycle
  always_comb begin
    strb.takeDefaults = rst;
    strb.capture      = rst | loadStrobe;
  end

endmodule

// File: rtl/clk_div_dp.sv
module clk_div_dp
  import clk_div_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DEF_DIV  = 2,
  parameter int DEF_HIGH = 1,
  parameter int DEF_INIT = 0
) (
  input  logic             clk,
  input  divStrobe_t       strb,
  input  logic [CNT_W-1:0] divisorIn,
  input  logic [CNT_W-1:0] highCyclesIn,
  input  logic [CNT_W-1:0] initCountIn,
  output logic             divClkOut
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] divReg, highReg, cntReg;
  logic [CNT_W-1:0] srcDiv, srcHigh, srcInit;
  logic [CNT_W-1:0] effDiv, startCnt, wrapCnt;
  logic [CNT_W-1:0] nextCnt, nextHigh;
  logic             nextUnity, nextOut;

  // Source of new configuration
  always_comb begin
    srcDiv  = strb.takeDefaults ? CNT_W'(DEF_DIV)  : divisorIn;
    srcHigh = strb.takeDefaults ? CNT_W'(DEF_HIGH) : highCyclesIn;
    srcInit = strb.takeDefaults ? CNT_W'(DEF_INIT) : initCountIn;
    effDiv  = (srcDiv < TWO) ? ONE : srcDiv;
    startCnt = srcInit % effDiv;
  end

  // Free-running count with wrap at divisor-1
  always_comb begin
    wrapCnt = (cntReg == divReg - ONE) ? ZERO : cntReg + ONE;
  end

  // Select next state: restart on capture, else advance
  always_comb begin
    if (strb.capture) begin
      nextCnt   = startCnt;
      nextHigh  = srcHigh;
      nextUnity = (effDiv == ONE);
    end else begin
      nextCnt   = wrapCnt;
      nextHigh  = highReg;
      nextUnity = (divReg == ONE);
    end
    nextOut = nextUnity | (nextCnt < nextHigh);
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      divReg  <= effDiv;
      highReg <= srcHigh;
    end
    cntReg    <= nextCnt;
    divClkOut <= nextOut;
  end

endmodule

// File: rtl/clk_div_top.sv
module clk_div_top
  import clk_div_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DEF_DIV  = 2,
  parameter int DEF_HIGH = 1,
  parameter int DEF_INIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadStrobe,
  input  logic [CNT_W-1:0] divisorIn,
  input  logic [CNT_W-1:0] highCyclesIn,
  input  logic [CNT_W-1:0] initCountIn,
  output logic             divClkOut
);

  divStrobe_t strb;

  clk_div_ctrl ctrl_i (
    .rst        (rst),
    .loadStrobe (loadStrobe),
    .strb       (strb)
  );

  clk_div_dp #(
    .CNT_W    (CNT_W),
    .DEF_DIV  (DEF_DIV),
    .DEF_HIGH (DEF_HIGH),
    .DEF_INIT (DEF_INIT)
  ) dp_i (
    .clk          (clk),
    .strb         (strb),
    .divisorIn    (divisorIn),
    .highCyclesIn (highCyclesIn),
    .initCountIn  (initCountIn),
    .divClkOut    (divClkOut)
  );

endmodule

// File: rtl/clk_div_chk.sv
module clk_div_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             loadStrobe,
  input logic [CNT_W-1:0] divisorIn,
  input logic [CNT_W-1:0] highCyclesIn,
  input logic [CNT_W-1:0] initCountIn,
  input logic             divClkOut
);

  // R1
  reset_default_high_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> divClkOut);

  // R6
  unity_div_high_chk: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && divisorIn < CNT_W'(2)) |=> divClkOut);

  // R7
  zero_high_low_chk: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && divisorIn >= CNT_W'(2) && highCyclesIn == '0) |=> !divClkOut);

  // R4
  start_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && divisorIn >= CNT_W'(2) && initCountIn < divisorIn)
      |=> (divClkOut == ($past(initCountIn) < $past(highCyclesIn))));

endmodule

bind clk_div_top clk_div_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/clk_div_top_tb_top.sv
`timescale 1ns/1ps
module clk_div_top_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         loadStrobe = 1'b0;
  logic [W-1:0] divisorIn = '0;
  logic [W-1:0] highCyclesIn = '0;
  logic [W-1:0] initCountIn = '0;
  logic         divClkOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  clk_div_top #(.CNT_W(W)) dut_i (.*);

  // one edge, then settle away from the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int expOut(int dv, int hi, int st, int k);
    int d;
    int pos;
    d = (dv < 2) ? 1 : dv;
    if (d == 1) return 1;
    pos = ((st % d) + k) % d;
    return (pos < hi) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: divClkOut=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic loadCfg(int dv, int hi, int st);
    divisorIn    = W'(dv);
    highCyclesIn = W'(hi);
    initCountIn  = W'(st);
    loadStrobe   = 1'b1;
    tick();
    loadStrobe   = 1'b0;
  endtask

  // compare n cycles against model, starting just after a capture edge
  task automatic checkSeq(string req, int dv, int hi, int st, int n);
    for (int k = 0; k < n; k++) begin
      check(req, int'(divClkOut), expOut(dv, hi, st, k));
      tick();
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    checkSeq("R1 defaults", 2, 1, 0, 8);
  endtask

  task automatic testDivide();
    loadCfg(5, 2, 0);
    checkSeq("R2 R3 div5 high2", 5, 2, 0, 15);
    loadCfg(7, 3, 0);
    checkSeq("R2 R3 div7 high3", 7, 3, 0, 14);
    loadCfg(3, 1, 0);
    checkSeq("R2 R3 div3 high1", 3, 1, 0, 9);
  endtask

  task automatic testPhase();
    loadCfg(6, 2, 4);
    checkSeq("R4 start4", 6, 2, 4, 12);
    loadCfg(4, 1, 9);
    checkSeq("R5 start9 mod4", 4, 1, 1, 8);
  endtask

  task automatic testUnity();
    loadCfg(0, 0, 3);
    checkSeq("R6 div0", 1, 0, 0, 5);
    loadCfg(1, 0, 0);
    checkSeq("R6 div1", 1, 0, 0, 5);
  endtask

  task automatic testExtremes();
    loadCfg(5, 0, 0);
    for (int k = 0; k < 10; k++) begin
      check("R7 high0", int'(divClkOut), 0);
      tick();
    end
    loadCfg(5, 8, 2);
    for (int k = 0; k < 10; k++) begin
      check("R7 high>=div", int'(divClkOut), 1);
      tick();
    end
  endtask

  task automatic testIgnore();
    loadCfg(5, 2, 0);
    divisorIn    = W'(3);
    highCyclesIn = W'(0);
    initCountIn  = W'(2);
    checkSeq("R8 inputs ignored", 5, 2, 0, 15);
  endtask

  task automatic testReload();
    loadCfg(6, 3, 0);
    tick();
    tick();
    loadCfg(6, 3, 5);
    checkSeq("R9 mid-period reload", 6, 3, 5, 12);
  endtask

  task automatic testCollision();
    divisorIn    = W'(5);
    highCyclesIn = W'(0);
    initCountIn  = W'(1);
    loadStrobe   = 1'b1;
    rst          = 1'b1;
    tick();
    loadStrobe   = 1'b0;
    rst          = 1'b0;
    checkSeq("R10 reset beats load", 2, 1, 0, 8);
  endtask

  initial begin
    tick();
    testReset();
    testDivide();
    testPhase();
    testUnity();
    testExtremes();
    testIgnore();
    testReload();
    testCollision();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule